// File: doc/BRIEF.md
# Display Memory Address Sequencer

This block turns a stream of instruction and data bytes from a host into 16-bit word writes for three display memories: the text memory that holds character codes, the user glyph memory, and the bitmap memory. Each word arrives as two consecutive data bytes, the upper byte first. The block keeps the one address counter the host sees. It decodes the instructions that point the counter at a memory, and it steps the counter after every completed word in the direction set by the entry mode.

The text and glyph memories use a single 6-bit counter. The bitmap memory uses a 6-bit row and a 4-bit column. The host sets them with two back-to-back instructions, row first and column second. The column moves with each word and wraps within the row, and the row never changes on its own. A clear instruction rewinds the counter and sweeps the whole text memory with blank codes (2020h). A home instruction only rewinds the counter. After every accepted instruction a busy output stays high for a programmable number of cycles, and for a longer time after clear. While busy is high, every incoming byte is dropped.

Top module: `disp_addr_seq`

## Requirements
- R1: After reset, busy is 0, mem_we is 0, addr_count is 0, the text memory is selected and the entry direction is increment.
- R2: Data bytes pair into words, upper byte first. After the first byte nothing is written and addr_count does not change. One cycle after the second byte, mem_we pulses for one cycle with mem_wdata = {first, second}, mem_sel and mem_addr showing the address before the step.
- R3: The entry instruction 0000_01d? (basic set) sets the direction: d=1 adds 1 after each word and d=0 subtracts 1. Text and glyph addresses wrap modulo 64.
- R4: In the basic set, 1?aa_aaaa loads the counter with aaaaaa and selects the text memory (mem_sel 0). Codes 80h–BFh therefore reach words 0–63, in four lines of 16.
- R5: In the basic set, 01aa_aaaa loads the counter and selects the glyph memory (mem_sel 1) only while the scroll-select flag is 0. While the flag is 1 this instruction has no effect. The flag is written by 0000_001s in the extended set.
- R6: 001?_?e?? in either set makes bit 2 the set selector (1 = extended). In the extended set, two consecutive instructions 1?xx_xxxx set the bitmap address: the first gives the row from bits 5:0, the second gives the column from bits 3:0 and selects the bitmap memory (mem_sel 2). Any other instruction in between restarts the pair. The bitmap address is {row, column}.
- R7: A completed bitmap word moves the column by +1 or −1 (per R3) modulo 16. The row stays unchanged.
- R8: Clear (01h, basic set) sets the counter to 0, forces increment and selects the text memory. It then writes 2020h to text words 0 to 63 in ascending order, one per cycle starting two cycles after acceptance, and keeps busy high for CLEAR_CYC cycles.
- R9: Home (0000_001?, basic set) sets the counter to 0, selects the text memory and writes nothing.
- R10: Shift 0001_sr?? (basic set): with s=0 the counter moves +1 for r=1 and −1 for r=0. With s=1 the counter is unchanged.
- R11: Any address-set instruction, clear or home discards a pending first data byte, so the next data byte counts as an upper byte.
- R12: Each accepted instruction holds busy high for exactly BUSY_CYC cycles (CLEAR_CYC for clear). Bytes offered while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One byte offered this cycle |
| wr_data_sel | input | 1 | 1 = data byte, 0 = instruction byte |
| wr_byte | input | 8 | Offered byte |
| busy | output | 1 | Instruction processing in progress, input ignored |
| addr_count | output | 10 | Current counter: {row, column} for bitmap, else zero-extended 6-bit counter |
| mem_sel | output | 2 | Target memory: 0 text, 1 glyph, 2 bitmap |
| mem_addr | output | 10 | Word address of the write |
| mem_wdata | output | 16 | Word written |
| mem_we | output | 1 | Write strobe, one cycle per word |

## Verification
Two things happen at the same edge: the word write, which must carry the old address, and the counter step, which may wrap the bitmap column from 0Fh to 00h. Words are written across the wrap in both directions, and every cycle the bench compares the write address and addr_count against a behavioural model. A second overlap happens when a byte arrives on the cycle busy falls. Bytes are offered in the final busy cycles of a clear and of ordinary instructions, and the bench checks that only bytes offered after busy is low take effect.

// File: rtl/disp_addr_seq.sv
module disp_addr_seq #(
  parameter int BUSY_CYC  = 8,
  parameter int CLEAR_CYC = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_data_sel,
  input  logic [7:0]  wr_byte,
  output logic        busy,
  output logic [9:0]  addr_count,
  output logic [1:0]  mem_sel,
  output logic [9:0]  mem_addr,
  output logic [15:0] mem_wdata,
  output logic        mem_we
);
  localparam int TEXT_W = 6;
  localparam int VERT_W = 6;
  localparam int HORZ_W = 4;
  localparam int ADDR_W = VERT_W + HORZ_W;
  localparam int BMAX   = (CLEAR_CYC > BUSY_CYC) ? CLEAR_CYC : BUSY_CYC;
  localparam int BCNT_W = $clog2(BMAX + 1);
  localparam logic [1:0] SEL_TXT = 2'd0, SEL_FNT = 2'd1, SEL_BMP = 2'd2;

  logic [TEXT_W-1:0] txt_q, fill_idx;
  logic [VERT_W-1:0] vert_q;
  logic [HORZ_W-1:0] horz_q;
  logic [1:0]        sel_q;
  logic              inc_q, ext_q, sr_q, phase_q, gph_q, fill_on;
  logic [7:0]        hi_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              acc;

  assign busy       = bcnt_q != '0;
  assign acc        = wr_en && !busy;
  assign addr_count = (sel_q == SEL_BMP) ? {vert_q, horz_q}
                                         : {{(ADDR_W-TEXT_W){1'b0}}, txt_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txt_q <= '0; vert_q <= '0; horz_q <= '0; sel_q <= SEL_TXT;
      inc_q <= 1'b1; ext_q <= 1'b0; sr_q <= 1'b0; phase_q <= 1'b0;
      gph_q <= 1'b0; hi_q <= '0; bcnt_q <= '0; fill_on <= 1'b0;
      fill_idx <= '0; mem_we <= 1'b0; mem_sel <= SEL_TXT;
      mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) bcnt_q <= bcnt_q - BCNT_W'(1);
      if (fill_on) begin
        mem_we    <= 1'b1;
        mem_sel   <= SEL_TXT;
        mem_addr  <= {{(ADDR_W-TEXT_W){1'b0}}, fill_idx};
        mem_wdata <= 16'h2020;
        fill_idx  <= fill_idx + TEXT_W'(1);
        if (&fill_idx) fill_on <= 1'b0;
      end
      if (acc && wr_data_sel) begin
        if (!phase_q) begin
          hi_q    <= wr_byte;
          phase_q <= 1'b1;
        end else begin
          phase_q   <= 1'b0;
          mem_we    <= 1'b1;
          mem_sel   <= sel_q;
          mem_addr  <= addr_count;
          mem_wdata <= {hi_q, wr_byte};
          if (sel_q == SEL_BMP) horz_q <= inc_q ? horz_q + HORZ_W'(1) : horz_q - HORZ_W'(1);
          else                  txt_q  <= inc_q ? txt_q + TEXT_W'(1) : txt_q - TEXT_W'(1);
        end
      end
      if (acc && !wr_data_sel) begin
        bcnt_q <= BCNT_W'(BUSY_CYC);
        gph_q  <= 1'b0;
        if (wr_byte[7:5] == 3'b001) ext_q <= wr_byte[2];
        else if (!ext_q) begin
          casez (wr_byte)
            8'b0000_0001: begin
              txt_q <= '0; inc_q <= 1'b1; sel_q <= SEL_TXT; phase_q <= 1'b0;
              bcnt_q <= BCNT_W'(CLEAR_CYC); fill_on <= 1'b1; fill_idx <= '0;
            end
            8'b0000_001?: begin txt_q <= '0; sel_q <= SEL_TXT; phase_q <= 1'b0; end
            8'b0000_01??: inc_q <= wr_byte[1];
            8'b0001_????: if (!wr_byte[3])
                            txt_q <= wr_byte[2] ? txt_q + TEXT_W'(1) : txt_q - TEXT_W'(1);
            8'b01??_????: if (!sr_q) begin
                            txt_q <= wr_byte[TEXT_W-1:0]; sel_q <= SEL_FNT; phase_q <= 1'b0;
                          end
            8'b1???_????: begin txt_q <= wr_byte[TEXT_W-1:0]; sel_q <= SEL_TXT; phase_q <= 1'b0; end
            default: ;
          endcase
        end else begin
          casez (wr_byte)
            8'b0000_001?: sr_q <= wr_byte[0];
            8'b1???_????: begin
              phase_q <= 1'b0;
              if (!gph_q) begin
                vert_q <= wr_byte[VERT_W-1:0];
                gph_q  <= 1'b1;
              end else begin
                horz_q <= wr_byte[HORZ_W-1:0];
                sel_q  <= SEL_BMP;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assert_first_byte_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_data_sel && !phase_q) |=> ($stable(addr_count) && !mem_we));
  assert_word_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_data_sel && phase_q) |=> (mem_we && mem_wdata[7:0] == $past(wr_byte)));
  assert_row_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_data_sel && phase_q && sel_q == SEL_BMP) |=> $stable(addr_count[ADDR_W-1:HORZ_W]));
  assert_instr_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr_data_sel) |=> busy);
  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fill_on) |=> !mem_we);
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr_data_sel && !ext_q && wr_byte == 8'h01) |=> (addr_count == '0 && busy));
endmodule

// File: tb/tb_disp_addr_seq.sv
`timescale 1ns/1ps
module tb_disp_addr_seq;
  localparam int BUSY  = 8;
  localparam int CLRC  = 80;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_data_sel = 0;
  logic [7:0] wr_byte = 0;
  logic busy, mem_we;
  logic [9:0] addr_count, mem_addr;
  logic [1:0] mem_sel;
  logic [15:0] mem_wdata;

  disp_addr_seq #(.BUSY_CYC(BUSY), .CLEAR_CYC(CLRC)) dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int m_txt, m_v, m_h, m_sel, m_inc, m_ext, m_sr, m_ph, m_hi, m_gph, m_busy, m_fill;
  int e_we, e_sel, e_addr, e_data;

  function automatic int cur_addr();
    return (m_sel == 2) ? (m_v * 16 + m_h) : m_txt;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_txt = 0; m_v = 0; m_h = 0; m_sel = 0; m_inc = 1; m_ext = 0; m_sr = 0;
      m_ph = 0; m_hi = 0; m_gph = 0; m_busy = 0; m_fill = -1; e_we = 0;
      e_sel = 0; e_addr = 0; e_data = 0;
    end else begin
      automatic bit take = wr_en && (m_busy == 0);
      automatic int b = wr_byte;
      automatic int g_next = 0;
      e_we = 0;
      if (m_busy > 0) m_busy--;
      if (m_fill >= 0) begin
        e_we = 1; e_sel = 0; e_addr = m_fill; e_data = 16'h2020;
        m_fill++;
        if (m_fill == 64) m_fill = -1;
      end
      if (take && wr_data_sel) begin
        if (m_ph == 0) begin m_hi = b; m_ph = 1; end
        else begin
          m_ph = 0; e_we = 1; e_sel = m_sel; e_addr = cur_addr(); e_data = m_hi * 256 + b;
          if (m_sel == 2) m_h = (m_h + (m_inc ? 1 : 15)) % 16;
          else            m_txt = (m_txt + (m_inc ? 1 : 63)) % 64;
        end
      end
      if (take && !wr_data_sel) begin
        m_busy = BUSY;
        if ((b >> 5) == 1) m_ext = (b >> 2) & 1;
        else if (m_ext == 0) begin
          if (b == 1) begin
            m_txt = 0; m_inc = 1; m_sel = 0; m_ph = 0; m_busy = CLRC; m_fill = 0;
          end else if ((b >> 1) == 1) begin m_txt = 0; m_sel = 0; m_ph = 0; end
          else if ((b >> 2) == 1) m_inc = (b >> 1) & 1;
          else if ((b >> 4) == 1) begin
            if (((b >> 3) & 1) == 0) m_txt = (m_txt + (((b >> 2) & 1) ? 1 : 63)) % 64;
          end else if ((b >> 6) == 1) begin
            if (m_sr == 0) begin m_txt = b % 64; m_sel = 1; m_ph = 0; end
          end else if (b >= 128) begin m_txt = b % 64; m_sel = 0; m_ph = 0; end
        end else begin
          if ((b >> 1) == 1) m_sr = b & 1;
          else if (b >= 128) begin
            m_ph = 0;
            if (m_gph == 0) begin m_v = b % 64; g_next = 1; end
            else begin m_h = b % 16; m_sel = 2; end
          end
        end
        m_gph = g_next;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(busy == (m_busy != 0), "R12", "busy", busy, m_busy != 0);
      check(addr_count == cur_addr(), cur_req, "addr_count", addr_count, cur_addr());
      check(mem_we == e_we, cur_req, "mem_we", mem_we, e_we);
      if (e_we && mem_we) begin
        check(mem_sel == e_sel, cur_req, "mem_sel", mem_sel, e_sel);
        check(mem_addr == e_addr, cur_req, "mem_addr", mem_addr, e_addr);
        check(mem_wdata == e_data, cur_req, "mem_wdata", mem_wdata, e_data);
      end
    end
  end

  task automatic put(input bit d, input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data_sel = d; wr_byte = b;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic idle();
    while (busy) @(negedge clk);
  endtask
  task automatic ins(input logic [7:0] b);
    put(0, b); idle();
  endtask
  task automatic word(input logic [15:0] w);
    put(1, w[15:8]); put(1, w[7:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check(busy == 0 && addr_count == 0 && mem_we == 0, "R1", "reset state", addr_count, 0);

    cur_req = "R4"; ins(8'h85);                       // text word 5
    cur_req = "R2"; word(16'h1234); word(16'hABCD);   // 5 then 6, ascending
    cur_req = "R4"; ins(8'hBF); word(16'h0102);       // last text word wraps to 0
    cur_req = "R3"; ins(8'h04); ins(8'h80); word(16'h5566); word(16'h7788);
    ins(8'h06);
    cur_req = "R5"; ins(8'h7F); word(16'h9999);       // glyph 3Fh
    ins(8'h34); ins(8'h03); ins(8'h30);               // scroll-select flag = 1
    ins(8'h45); word(16'h1111);                       // ignored set: counter continues
    ins(8'h34); ins(8'h02); ins(8'h30);
    ins(8'h45); word(16'h2222);
    cur_req = "R11"; put(1, 8'hAA); ins(8'h81); word(16'h1122);
    put(1, 8'h33); ins(8'h02); word(16'h4455);
    cur_req = "R6"; ins(8'h34); ins(8'hAA); ins(8'h8E);
    cur_req = "R7"; word(16'hF00D); word(16'hBEEF); word(16'hCAFE);
    cur_req = "R6"; ins(8'h85); ins(8'h03); ins(8'h81); ins(8'h82); word(16'h0A0B);
    cur_req = "R7"; ins(8'h30); ins(8'h04); ins(8'h34); ins(8'h83); ins(8'h80);
    word(16'h1357); word(16'h2468);
    ins(8'h30); ins(8'h06);
    cur_req = "R10"; ins(8'h8A); ins(8'h10); ins(8'h14); ins(8'h14); ins(8'h18); ins(8'h1C);
    ins(8'h80); ins(8'h10);
    cur_req = "R9"; ins(8'h93); ins(8'h02); word(16'h0F0F);
    cur_req = "R8"; ins(8'h04); ins(8'h97);
    put(0, 8'h01);
    put(1, 8'h77); put(1, 8'h88);                     // offered while busy
    idle(); word(16'h6060);
    cur_req = "R12"; put(0, 8'h84); put(0, 8'h88); put(1, 8'h01);
    repeat (BUSY - 3) @(negedge clk);
    put(1, 8'h42); put(1, 8'h43); put(1, 8'h44); idle(); put(1, 8'h45);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule